// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side each have their own clock. The two clocks may be the same net or may run with no fixed relation to each other. A word enters on a write-clock edge when both write enables agree. A word leaves on a read-clock edge when both read enables agree. The read side holds its result in an output register.

Four status outputs report the fill level:
- Empty and Almost-Empty are computed against the read clock.
- Full and Almost-Full are computed against the write clock.

The two "almost" thresholds come from a pair of offset words. A load strobe switches the data ports into a configuration mode. In that mode, writes store into the offsets and reads return the offsets. A small two-state selector steps through the Almost-Empty offset first and the Almost-Full offset second, then returns to the first.

An output enable gates the read bus. Inactive, it drives the bus to zero and lowers a valid strobe. This stands in for a high-impedance bus.

Top module: `pff_fifo_top`

## Requirements
- R1: With the load strobe high, a write edge where `wen1_n`=0 and `wen2`=1 while not full stores `din`. Stored words come out on `q` in the order written, one per accepted read edge.
- R2: A write edge with `wen1_n`=1 or with `wen2`=0 stores nothing, and `empty` stays 1 on an empty buffer.
- R3: A read happens only when `ren1_n`=0 and `ren2_n`=0 on the same edge. With only one of them low, `q` keeps its value and the occupancy is unchanged.
- R4: `full` is 1 exactly when DEPTH words are held, and `empty` is 1 exactly when none are held. `empty` deasserts by the third read-clock edge after the first write.
- R5: A write while full and a read while empty are both ignored. Neither pointer moves, no stored word is overwritten, and `q` keeps its previous value.
- R6: After `rst`=1 is sampled, the outputs are `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `q`=0, and both offsets read back as 7.
- R7: `almost_empty` is 1 when the occupancy is at most the Almost-Empty offset, and 0 above it.
- R8: `almost_full` is 1 when the occupancy is at least DEPTH minus the Almost-Full offset, and 0 below it.
- R9: With `ld_n`=0, each accepted write edge stores the low bits of `din` into an offset rather than the buffer. The first goes to the Almost-Empty offset, the next to the Almost-Full offset, and then the sequence wraps.
- R10: With `ld_n`=0, each accepted read edge loads `q` with an offset (zero-extended) without moving the read pointer. The order is Almost-Empty first, then Almost-Full, wrapping.
- R11: With `oe`=0, `q_vld`=0 and `q`=0. With `oe`=1, `q_vld`=1 and `q` shows the read register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock (may be tied to `wclk`) |
| rst | input | 1 | Synchronous active-high reset, held for several edges of both clocks |
| wen1_n | input | 1 | Write enable, active low |
| wen2 | input | 1 | Write enable, active high |
| ld_n | input | 1 | Offset configuration strobe, active low |
| din | input | 9 | Write data or offset value |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe | input | 1 | Output enable for the read bus |
| q | output | 9 | Read data, zero while `oe` is low |
| q_vld | output | 1 | Read bus valid (stands in for a driven bus) |
| empty | output | 1 | Buffer holds no words (read domain) |
| almost_empty | output | 1 | Occupancy at or below the Almost-Empty offset (read domain) |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| almost_full | output | 1 | Occupancy at or above DEPTH minus the Almost-Full offset (write domain) |

## Verification
The hardest state to reach is a full buffer that then receives one more write, with a later drain that shows nothing was overwritten. The stimulus first moves both pointers away from zero with a short fill and drain. It then writes exactly DEPTH words, checks Almost-Full at the word where the threshold is crossed, and adds one extra write with a distinctive value. A scoreboard then tracks the whole drain so that any lost or replaced word shows up as a mismatch. Before that, the offsets are loaded with three values so the third wraps back to the first slot. A readback of three words then confirms both the order and the wrap.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int DATA_W     = 9;
    localparam int PTR_MAX_W  = 13;
    localparam int DEF_OFFSET = 7;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } off_sel_e;

    typedef struct packed {
        logic full;
        logic almost_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [PTR_MAX_W-1:0] to_gray(input logic [PTR_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX_W-1:0] from_gray(input logic [PTR_MAX_W-1:0] g);
        logic [PTR_MAX_W-1:0] b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic off_sel_e next_sel(input off_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

endpackage

// File: rtl/pff_sync2.sv
module pff_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side
    import pff_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          ld_active,
    input  logic [AW-1:0] ld_val,
    input  logic [AW:0]   rptr_gray_s,
    output logic [AW:0]   wptr_gray,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output wr_flags_t     flags
);

    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] wptr_inc;
    logic [PW-1:0] rptr_bin_s;
    logic [PW-1:0] occ;
    logic [PW-1:0] af_level;
    logic          cfg_we;
    off_sel_e      sel;

    always_comb begin
        rptr_bin_s        = PW'(from_gray(PTR_MAX_W'(rptr_gray_s)));
        occ               = wptr_bin - rptr_bin_s;
        af_level          = PW'(DEPTH) - {1'b0, af_off};
        flags.full        = (occ == PW'(DEPTH));
        flags.almost_full = (occ >= af_level);
        mem_we            = wr_req && !ld_active && !flags.full;
        cfg_we            = wr_req && ld_active;
        waddr             = wptr_bin[AW-1:0];
        wptr_inc          = wptr_bin + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else if (mem_we) begin
            wptr_bin  <= wptr_inc;
            wptr_gray <= PW'(to_gray(PTR_MAX_W'(wptr_inc)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= SEL_AE;
            ae_off <= AW'(DEF_OFFSET);
            af_off <= AW'(DEF_OFFSET);
        end else if (cfg_we) begin
            if (sel == SEL_AE) begin
                ae_off <= ld_val;
            end else begin
                af_off <= ld_val;
            end
            sel <= next_sel(sel);
        end
    end

    // R5
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.full && wr_req && !ld_active) |=> $stable(wptr_bin));

    // R4
    occ_range_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH));

    // R8
    full_implies_af_chk: assert property (@(posedge clk) disable iff (rst)
        flags.full |-> flags.almost_full);

    // R9
    ae_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && sel == SEL_AE) |=> (ae_off == $past(ld_val)));

    // R9
    cfg_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        ld_active |=> $stable(wptr_bin));

endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
    import pff_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          ld_active,
    input  logic [AW:0]   wptr_gray_s,
    input  logic [DW-1:0] mem_q,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] ae_rb,
    input  logic [DW-1:0] af_rb,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_gray,
    output logic [DW-1:0] dout,
    output rd_flags_t     flags
);

    localparam int PW = AW + 1;

    logic [PW-1:0] rptr_bin;
    logic [PW-1:0] rptr_inc;
    logic [PW-1:0] wptr_bin_s;
    logic [PW-1:0] occ;
    logic          pop;
    logic          peek;
    off_sel_e      sel;

    always_comb begin
        wptr_bin_s         = PW'(from_gray(PTR_MAX_W'(wptr_gray_s)));
        occ                = wptr_bin_s - rptr_bin;
        flags.empty        = (occ == '0);
        flags.almost_empty = (occ <= {1'b0, ae_off});
        pop                = rd_req && !ld_active && !flags.empty;
        peek               = rd_req && ld_active;
        raddr              = rptr_bin[AW-1:0];
        rptr_inc           = rptr_bin + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_bin  <= '0;
            rptr_gray <= '0;
        end else if (pop) begin
            rptr_bin  <= rptr_inc;
            rptr_gray <= PW'(to_gray(PTR_MAX_W'(rptr_inc)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            sel  <= SEL_AE;
        end else if (pop) begin
            dout <= mem_q;
        end else if (peek) begin
            dout <= (sel == SEL_AE) ? ae_rb : af_rb;
            sel  <= next_sel(sel);
        end
    end

    // R5
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && rd_req && !ld_active) |=> ($stable(rptr_bin) && $stable(dout)));

    // R7
    empty_implies_ae_chk: assert property (@(posedge clk) disable iff (rst)
        flags.empty |-> flags.almost_empty);

    // R10
    readback_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        ld_active |=> $stable(rptr_bin));

    // R3
    idle_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> ($stable(dout) && $stable(rptr_bin)));

endmodule

// File: rtl/pff_fifo_top.sv
module pff_fifo_top
    import pff_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wen1_n,
    input  logic              wen2,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe,
    output logic [DATA_W-1:0] q,
    output logic              q_vld,
    output logic              empty,
    output logic              almost_empty,
    output logic              full,
    output logic              almost_full
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              wr_req;
    logic              rd_req;
    logic              ld_active;
    logic [AW-1:0]     ld_val;
    logic [AW-1:0]     ae_off;
    logic [AW-1:0]     af_off;
    logic [DATA_W-1:0] ae_rb;
    logic [DATA_W-1:0] af_rb;
    logic [PW-1:0]     wptr_gray;
    logic [PW-1:0]     rptr_gray;
    logic [PW-1:0]     wptr_gray_s;
    logic [PW-1:0]     rptr_gray_s;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] dout;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    assign wr_req    = !wen1_n && wen2;
    assign rd_req    = !ren1_n && !ren2_n;
    assign ld_active = !ld_n;

    generate
        if (AW < DATA_W) begin : g_narrow_off
            assign ld_val = din[AW-1:0];
            assign ae_rb  = {{(DATA_W-AW){1'b0}}, ae_off};
            assign af_rb  = {{(DATA_W-AW){1'b0}}, af_off};
        end else if (AW == DATA_W) begin : g_equal_off
            assign ld_val = din;
            assign ae_rb  = ae_off;
            assign af_rb  = af_off;
        end else begin : g_wide_off
            assign ld_val = {{(AW-DATA_W){1'b0}}, din};
            assign ae_rb  = ae_off[DATA_W-1:0];
            assign af_rb  = af_off[DATA_W-1:0];
        end
    endgenerate

    pff_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk         (wclk),
        .rst         (rst),
        .wr_req      (wr_req),
        .ld_active   (ld_active),
        .ld_val      (ld_val),
        .rptr_gray_s (rptr_gray_s),
        .wptr_gray   (wptr_gray),
        .waddr       (waddr),
        .mem_we      (mem_we),
        .ae_off      (ae_off),
        .af_off      (af_off),
        .flags       (wflags)
    );

    pff_sync2 #(.W(PW)) u_sync_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wptr_gray),
        .q   (wptr_gray_s)
    );

    pff_sync2 #(.W(PW)) u_sync_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rptr_gray),
        .q   (rptr_gray_s)
    );

    pff_mem #(.DEPTH(DEPTH), .AW(AW), .DW(DATA_W)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (mem_q)
    );

    pff_rd_side #(.AW(AW), .DW(DATA_W)) u_rd (
        .clk         (rclk),
        .rst         (rst),
        .rd_req      (rd_req),
        .ld_active   (ld_active),
        .wptr_gray_s (wptr_gray_s),
        .mem_q       (mem_q),
        .ae_off      (ae_off),
        .ae_rb       (ae_rb),
        .af_rb       (af_rb),
        .raddr       (raddr),
        .rptr_gray   (rptr_gray),
        .dout        (dout),
        .flags       (rflags)
    );

    assign q            = oe ? dout : '0;
    assign q_vld        = oe;
    assign empty        = rflags.empty;
    assign almost_empty = rflags.almost_empty;
    assign full         = wflags.full;
    assign almost_full  = wflags.almost_full;

endmodule

// File: tb/pff_fifo_top_tb.sv
module pff_fifo_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       wen1_n, wen2, ld_n, ren1_n, ren2_n, oe;
    logic [8:0] din;
    logic [8:0] q;
    logic       q_vld, empty, almost_empty, full, almost_full;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pff_fifo_top #(.DEPTH(DEPTH)) u_dut (
        .wclk (clk), .rclk (clk), .rst (rst),
        .wen1_n (wen1_n), .wen2 (wen2), .ld_n (ld_n), .din (din),
        .ren1_n (ren1_n), .ren2_n (ren2_n), .oe (oe),
        .q (q), .q_vld (q_vld), .empty (empty), .almost_empty (almost_empty),
        .full (full), .almost_full (almost_full)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wen1_n = 1'b1; wen2 = 1'b0; ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic push(input logic [8:0] v);
        wen1_n = 1'b0; wen2 = 1'b1; din = v;
        exp_q.push_back(v);
        step();
    endtask

    // scoreboard monitor: sampled at the falling edge
    initial begin
        logic pend;
        pend = 1'b0;
        forever begin
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R1 unexpected read: actual %0h expected none", q);
                end else begin
                    check("R1", "read order", q, exp_q.pop_front());
                end
            end
            pend = !ren1_n && !ren2_n && ld_n && !empty && !rst;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; idle(); ld_n = 1'b1; oe = 1'b1; din = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R6", "empty", empty, 1);
        check("R6", "almost_empty", almost_empty, 1);
        check("R6", "full", full, 0);
        check("R6", "almost_full", almost_full, 0);
        check("R6", "q", q, 0);

        // default offsets readback
        ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        step(); check("R6", "ae offset default", q, 7);
        step(); check("R6", "af offset default", q, 7);
        idle();

        // R9: load three values, third wraps to AE
        wen1_n = 1'b0; wen2 = 1'b1;
        din = 9'd3; step();
        din = 9'd5; step();
        din = 9'd4; step();
        idle();
        ren1_n = 1'b0; ren2_n = 1'b0;
        step(); check("R10", "readback ae", q, 4);
        step(); check("R10", "readback af", q, 5);
        step(); check("R10", "readback wrap", q, 4);
        idle(); ld_n = 1'b1;
        repeat (3) step();
        check("R9", "load left buffer empty", empty, 1);

        // R2: single-enable writes
        wen1_n = 1'b0; wen2 = 1'b0; din = 9'h1AA; step();
        wen1_n = 1'b1; wen2 = 1'b1; step();
        idle(); repeat (3) step();
        check("R2", "empty after half-enabled writes", empty, 1);

        // R7: threshold at offset 4
        for (int i = 0; i < 4; i++) push(9'h100 + 9'(i));
        idle(); repeat (3) step();
        check("R4", "empty cleared", empty, 0);
        check("R7", "ae at occupancy 4", almost_empty, 1);
        push(9'h104);
        idle(); repeat (3) step();
        check("R7", "ae at occupancy 5", almost_empty, 0);
        check("R8", "af low", almost_full, 0);

        // R3: only one read enable at a time
        ren1_n = 1'b0; ren2_n = 1'b1; step();
        ren1_n = 1'b1; ren2_n = 1'b0; step();
        idle(); repeat (3) step();
        check("R3", "q held", q, 4);
        check("R3", "occupancy kept", almost_empty, 0);

        // drain
        ren1_n = 1'b0; ren2_n = 1'b0;
        repeat (5) step();
        idle(); repeat (3) step();
        check("R4", "empty after drain", empty, 1);
        ren1_n = 1'b0; ren2_n = 1'b0; repeat (2) step();
        idle(); step();
        check("R5", "q after empty read", q, 9'h104);

        // fill to full with offset af=5 -> threshold 59
        for (int i = 0; i < 58; i++) push(9'(i) ^ 9'h155);
        check("R8", "af at 58", almost_full, 0);
        push(9'h0F0);
        check("R8", "af at 59", almost_full, 1);
        check("R4", "not full at 59", full, 0);
        for (int i = 0; i < 5; i++) push(9'h0A0 + 9'(i));
        check("R4", "full at 64", full, 1);
        wen1_n = 1'b0; wen2 = 1'b1; din = 9'h0EE; step();
        idle(); step();
        check("R5", "still full", full, 1);

        // R11
        oe = 1'b0; #1;
        check("R11", "q_vld low", q_vld, 0);
        check("R11", "q zero", q, 0);
        oe = 1'b1; #1;
        check("R11", "q_vld high", q_vld, 1);
        check("R11", "q restored", q, 9'h104);

        ren1_n = 1'b0; ren2_n = 1'b0;
        repeat (DEPTH + 2) step();
        idle(); repeat (3) step();
        check("R5", "scoreboard drained", exp_q.size(), 0);
        check("R5", "empty after full drain", empty, 1);
        check("R4", "full cleared", full, 0);
        check("R8", "af cleared", almost_full, 0);
        check("R7", "ae at zero", almost_empty, 1);

        finish_run();
    end

endmodule